// File: doc/BRIEF.md
# Character LCD Bus Controller with Programmable Access Timing

This block connects a host to a parallel character-display bus of the asynchronous 6800 kind. Each access has three phases. In the setup phase the register-select and read/write lines are valid and no enable is active. In the strobe phase one enable is high. In the hold phase the enable is low again, but the lines and the write data are still held. A chip-select recovery gap follows before the next access can start. Writes and reads each have their own setup, strobe and hold counts. The recovery gap is common to both. The cycle counts come in on configuration inputs and are captured when a request is accepted.

The host starts an access by raising `req_valid` while `busy` is low. The request carries an access type, a display select and write data. The type encodes both bus lines: bit 0 drives register-select and bit 1 drives read/write. Two enable outputs let one bus serve two display controllers. On a read the data bus is released, and the value on `lcd_d_in` is captured into `rd_data` at the end of the strobe.

Top module: `char_lcd_bus_ctrl`

## Requirements
- R1: A write runs setup for `cfg_w_setup` cycles with both enables low. It then runs strobe for `cfg_w_strobe` cycles with the selected enable high, then hold for `cfg_w_hold` cycles with both enables low.
- R2: A setup count of 0 skips the setup phase. The enable then rises in the first cycle after acceptance.
- R3: A strobe or hold count of 0 is treated as 1 cycle.
- R4: A read uses `cfg_r_setup`, `cfg_r_strobe` and `cfg_r_hold` the same way R1 describes, independent of the write counts.
- R5: After the hold phase, `busy` stays high for `cfg_cs_gap` more cycles with no enable active. A gap of 0 adds no cycles.
- R6: `lcd_rs` equals `req_type[0]` and `lcd_rw` equals `req_type[1]` for the whole access. The type codes are 00 write command, 01 write data, 10 read status and 11 read data.
- R7: `req_disp` = 0 pulses `lcd_e[0]` and `req_disp` = 1 pulses `lcd_e[1]`. The other enable stays low for the whole access.
- R8: For a write, `lcd_d_oe` is 1 and `lcd_d_out` equals the request's write data for every setup, strobe and hold cycle. For a read, and while idle or in the gap, `lcd_d_oe` is 0 (bus in high impedance).
- R9: On a read, `rd_data` takes the value of `lcd_d_in` at the clock edge that ends the last strobe cycle. `rd_done` pulses high for one cycle right after that edge.
- R10: `busy` rises in the cycle after a request is accepted (`req_valid` high while `busy` low) and stays high until the gap ends. A request held during `busy` changes nothing in the access in progress.
- R11: Changing the configuration inputs or the request inputs during an access does not change that access's timing, lines or data.
- R12: Synchronous reset `rst` returns the block to idle in the next cycle: `busy` low, both enables low, `lcd_d_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request |
| req_type | input | 2 | Access type: bit0 to RS, bit1 to R/W |
| req_disp | input | 1 | Display select (enable index) |
| req_wdata | input | 8 | Write data |
| cfg_w_setup | input | 5 | Write setup cycles, 0 to 31 |
| cfg_w_strobe | input | 6 | Write strobe cycles, 1 to 63 |
| cfg_w_hold | input | 4 | Write hold cycles, 1 to 15 |
| cfg_r_setup | input | 5 | Read setup cycles, 0 to 31 |
| cfg_r_strobe | input | 6 | Read strobe cycles, 1 to 63 |
| cfg_r_hold | input | 4 | Read hold cycles, 1 to 15 |
| cfg_cs_gap | input | 5 | Recovery cycles after each access |
| busy | output | 1 | Access in progress; requests are held off |
| rd_data | output | 8 | Last captured read value |
| rd_done | output | 1 | One-cycle pulse after a read capture |
| lcd_rs | output | 1 | Register-select line |
| lcd_rw | output | 1 | Read/write line, 1 = read |
| lcd_e | output | 2 | Enable strobes, one per display |
| lcd_d_out | output | 8 | Data bus drive value |
| lcd_d_oe | output | 1 | Data bus output enable; 0 = high impedance |
| lcd_d_in | input | 8 | Data bus sampled value |

## Verification
The assertions assume that `rst` is held for at least one clock edge before any request. They also assume that `lcd_d_in` is driven only to meaningful levels, never X. The properties on line stability and single-enable activity rely only on the design's own outputs, so they hold for any request pattern. The bench drives requests only at falling edges. During an access it changes the configuration and request inputs at random to exercise R10 and R11. It lowers `req_valid` on the last busy cycle it expects, so that each run covers exactly one access.

// File: rtl/char_lcd_pkg.sv
package char_lcd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_GAP    = 3'd4
  } lcd_phase_e;

  localparam int unsigned TYPE_W = 2;
  localparam int unsigned TYPE_RS_BIT = 0;
  localparam int unsigned TYPE_RW_BIT = 1;

endpackage

// File: rtl/lcd_phase_counter.sv
module lcd_phase_counter #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
  import char_lcd_pkg::*;
#(
  parameter int unsigned SETUP_W  = 5,
  parameter int unsigned STROBE_W = 6,
  parameter int unsigned HOLD_W   = 4,
  parameter int unsigned GAP_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                is_read,
  input  logic [SETUP_W-1:0]  w_setup,
  input  logic [STROBE_W-1:0] w_strobe,
  input  logic [HOLD_W-1:0]   w_hold,
  input  logic [SETUP_W-1:0]  r_setup,
  input  logic [STROBE_W-1:0] r_strobe,
  input  logic [HOLD_W-1:0]   r_hold,
  input  logic [GAP_W-1:0]    gap,
  output lcd_phase_e          phase,
  output logic                strobe_last,
  output logic                busy
);

  localparam int unsigned CW_A = (SETUP_W > STROBE_W) ? SETUP_W : STROBE_W;
  localparam int unsigned CW_B = (HOLD_W > GAP_W) ? HOLD_W : GAP_W;
  localparam int unsigned CW   = (CW_A > CW_B) ? CW_A : CW_B;

  // Counter preload for a phase of n cycles; 0 is stretched to one cycle.
  function automatic logic [CW-1:0] span(input logic [CW-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  lcd_phase_e phase_q, phase_d;
  logic [STROBE_W-1:0] strobe_q;
  logic [HOLD_W-1:0]   hold_q;
  logic [GAP_W-1:0]    gap_q;
  logic [SETUP_W-1:0]  sel_setup;
  logic [STROBE_W-1:0] sel_strobe;
  logic [HOLD_W-1:0]   sel_hold;
  logic                cnt_load;
  logic [CW-1:0]       cnt_val;
  logic                cnt_last;
  logic                accept_now;

  assign sel_setup  = is_read ? r_setup  : w_setup;
  assign sel_strobe = is_read ? r_strobe : w_strobe;
  assign sel_hold   = is_read ? r_hold   : w_hold;
  assign accept_now = (phase_q == PH_IDLE) && start;

  lcd_phase_counter #(.W(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_val),
    .last     (cnt_last)
  );

  always_comb begin
    phase_d  = phase_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (phase_q)
      PH_IDLE: if (start) begin
        cnt_load = 1'b1;
        if (sel_setup != '0) begin
          phase_d = PH_SETUP;
          cnt_val = span(CW'(sel_setup));
        end else begin
          phase_d = PH_STROBE;
          cnt_val = span(CW'(sel_strobe));
        end
      end
      PH_SETUP: if (cnt_last) begin
        phase_d  = PH_STROBE;
        cnt_load = 1'b1;
        cnt_val  = span(CW'(strobe_q));
      end
      PH_STROBE: if (cnt_last) begin
        phase_d  = PH_HOLD;
        cnt_load = 1'b1;
        cnt_val  = span(CW'(hold_q));
      end
      PH_HOLD: if (cnt_last) begin
        if (gap_q != '0) begin
          phase_d  = PH_GAP;
          cnt_load = 1'b1;
          cnt_val  = span(CW'(gap_q));
        end else begin
          phase_d = PH_IDLE;
        end
      end
      PH_GAP: if (cnt_last) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      strobe_q <= '0;
      hold_q   <= '0;
      gap_q    <= '0;
    end else begin
      phase_q <= phase_d;
      if (accept_now) begin
        strobe_q <= sel_strobe;
        hold_q   <= sel_hold;
        gap_q    <= gap;
      end
    end
  end

  assign phase       = phase_q;
  assign busy        = (phase_q != PH_IDLE);
  assign strobe_last = (phase_q == PH_STROBE) && cnt_last;

  AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE) |=> (phase_q inside {PH_IDLE, PH_SETUP, PH_STROBE})); // R2
  AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_HOLD) |-> ($past(phase_q) inside {PH_STROBE, PH_HOLD})); // R1

endmodule

// File: rtl/char_lcd_bus_ctrl.sv
module char_lcd_bus_ctrl
  import char_lcd_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned N_DISP   = 2,
  parameter int unsigned SETUP_W  = 5,
  parameter int unsigned STROBE_W = 6,
  parameter int unsigned HOLD_W   = 4,
  parameter int unsigned GAP_W    = 5,
  localparam int unsigned SEL_W   = (N_DISP > 1) ? $clog2(N_DISP) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [TYPE_W-1:0]   req_type,
  input  logic [SEL_W-1:0]    req_disp,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [SETUP_W-1:0]  cfg_w_setup,
  input  logic [STROBE_W-1:0] cfg_w_strobe,
  input  logic [HOLD_W-1:0]   cfg_w_hold,
  input  logic [SETUP_W-1:0]  cfg_r_setup,
  input  logic [STROBE_W-1:0] cfg_r_strobe,
  input  logic [HOLD_W-1:0]   cfg_r_hold,
  input  logic [GAP_W-1:0]    cfg_cs_gap,
  output logic                busy,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_done,
  output logic                lcd_rs,
  output logic                lcd_rw,
  output logic [N_DISP-1:0]   lcd_e,
  output logic [DATA_W-1:0]   lcd_d_out,
  output logic                lcd_d_oe,
  input  logic [DATA_W-1:0]   lcd_d_in
);

  lcd_phase_e          phase;
  logic                strobe_last;
  logic                accept;
  logic                in_access;
  logic                rs_q, rw_q;
  logic [SEL_W-1:0]    sel_q;
  logic [DATA_W-1:0]   wdata_q;

  assign accept = req_valid && !busy;

  lcd_phase_seq #(
    .SETUP_W (SETUP_W), .STROBE_W(STROBE_W), .HOLD_W(HOLD_W), .GAP_W(GAP_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (accept),
    .is_read    (req_type[TYPE_RW_BIT]),
    .w_setup    (cfg_w_setup),
    .w_strobe   (cfg_w_strobe),
    .w_hold     (cfg_w_hold),
    .r_setup    (cfg_r_setup),
    .r_strobe   (cfg_r_strobe),
    .r_hold     (cfg_r_hold),
    .gap        (cfg_cs_gap),
    .phase      (phase),
    .strobe_last(strobe_last),
    .busy       (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_q    <= 1'b0;
      rw_q    <= 1'b0;
      sel_q   <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      rs_q    <= req_type[TYPE_RS_BIT];
      rw_q    <= req_type[TYPE_RW_BIT];
      sel_q   <= req_disp;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_done <= 1'b0;
    end else begin
      rd_done <= strobe_last && rw_q;
      if (strobe_last && rw_q) rd_data <= lcd_d_in;
    end
  end

  for (genvar gi = 0; gi < N_DISP; gi++) begin : g_enable
    assign lcd_e[gi] = (phase == PH_STROBE) && (sel_q == SEL_W'(gi));
  end

  assign in_access = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign lcd_rs    = rs_q;
  assign lcd_rw    = rw_q;
  assign lcd_d_out = wdata_q;
  assign lcd_d_oe  = in_access && !rw_q;

  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lcd_e)); // R7
  AST_READ_HIZ: assert property (@(posedge clk) disable iff (rst)
    (lcd_rw && busy) |-> !lcd_d_oe); // R8
  AST_ENABLE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (|lcd_e) |-> busy); // R10
  AST_CTRL_STABLE: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_d_out)))); // R6
  AST_RD_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> (lcd_rw && !(|lcd_e) && $past(|lcd_e))); // R9
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!busy && (lcd_e == '0) && !lcd_d_oe)); // R12

endmodule

// File: tb/char_lcd_bus_ctrl_tb.sv
module char_lcd_bus_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid;
  logic [1:0] req_type;
  logic       req_disp;
  logic [7:0] req_wdata;
  logic [4:0] cfg_w_setup, cfg_r_setup, cfg_cs_gap;
  logic [5:0] cfg_w_strobe, cfg_r_strobe;
  logic [3:0] cfg_w_hold, cfg_r_hold;
  logic       busy, rd_done, lcd_rs, lcd_rw, lcd_d_oe;
  logic [7:0] rd_data, lcd_d_out, lcd_d_in;
  logic [1:0] lcd_e;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  char_lcd_bus_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_type(req_type),
    .req_disp(req_disp), .req_wdata(req_wdata),
    .cfg_w_setup(cfg_w_setup), .cfg_w_strobe(cfg_w_strobe), .cfg_w_hold(cfg_w_hold),
    .cfg_r_setup(cfg_r_setup), .cfg_r_strobe(cfg_r_strobe), .cfg_r_hold(cfg_r_hold),
    .cfg_cs_gap(cfg_cs_gap), .busy(busy), .rd_data(rd_data), .rd_done(rd_done),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e), .lcd_d_out(lcd_d_out),
    .lcd_d_oe(lcd_d_oe), .lcd_d_in(lcd_d_in)
  );

  function automatic int at_least_one(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [7:0] bus_pattern(input int idx);
    return 8'((idx * 37 + 11) ^ (idx >> 2));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic scramble_inputs();
    cfg_w_setup  = 5'($urandom); cfg_w_strobe = 6'($urandom); cfg_w_hold = 4'($urandom);
    cfg_r_setup  = 5'($urandom); cfg_r_strobe = 6'($urandom); cfg_r_hold = 4'($urandom);
    cfg_cs_gap   = 5'($urandom);
    req_type     = 2'($urandom); req_disp = 1'($urandom); req_wdata = 8'($urandom);
  endtask

  task automatic run_access(input logic [1:0] typ, input logic disp, input logic [7:0] wd,
                            input int ws, input int wt, input int wh,
                            input int rs_, input int rt, input int rh, input int gp,
                            input bit scramble);
    bit is_rd = typ[1];
    int s_exp = is_rd ? rs_ : ws;
    int t_exp = at_least_one(is_rd ? rt : wt);
    int h_exp = at_least_one(is_rd ? rh : wh);
    int n_exp = s_exp + t_exp + h_exp + gp;
    int busy_cnt = 0, first_e = -1, e_cnt = 0, oe_cnt = 0, wrong_e = 0;
    int ctrl_bad = 0, data_bad = 0, done_idx = -1, done_cnt = 0;
    logic [7:0] done_val = 8'h00;
    int i = 0;
    @(negedge clk);
    check(!busy, "R10 idle before request", busy, 0);
    cfg_w_setup = 5'(ws); cfg_w_strobe = 6'(wt); cfg_w_hold = 4'(wh);
    cfg_r_setup = 5'(rs_); cfg_r_strobe = 6'(rt); cfg_r_hold = 4'(rh);
    cfg_cs_gap = 5'(gp);
    req_type = typ; req_disp = disp; req_wdata = wd; req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (rd_done) begin done_cnt++; done_idx = i; done_val = rd_data; end
      if (!busy || i > 400) break;
      busy_cnt++;
      if (lcd_e[disp]) begin
        if (first_e < 0) first_e = i;
        e_cnt++;
      end
      if (lcd_e[~disp]) wrong_e++;
      if (lcd_rs !== typ[0] || lcd_rw !== typ[1]) ctrl_bad++;
      if (lcd_d_oe) begin
        oe_cnt++;
        if (lcd_d_out !== wd) data_bad++;
      end
      lcd_d_in = bus_pattern(i);
      if (i == 0) begin
        if (scramble) scramble_inputs(); else req_valid = 1'b0;
      end
      if (i == n_exp - 1) req_valid = 1'b0;
      i++;
    end
    req_valid = 1'b0;
    check(i <= 400, "R10 access finishes", i, n_exp);
    check(first_e == s_exp, is_rd ? "R4 read setup length" : (s_exp == 0 ? "R2 skipped setup" : "R1 write setup length"), first_e, s_exp);
    check(e_cnt == t_exp, is_rd ? "R4 read strobe length" : "R3 R1 write strobe length", e_cnt, t_exp);
    check(busy_cnt == n_exp, gp == 0 ? "R5 no gap total busy" : "R5 gap total busy", busy_cnt, n_exp);
    check(wrong_e == 0, "R7 other enable low", wrong_e, 0);
    check(ctrl_bad == 0, "R6 RS and RW lines", ctrl_bad, 0);
    check(ctrl_bad == 0 && data_bad == 0 || !scramble, "R11 lines unaffected by reprogramming", data_bad, 0);
    if (is_rd) begin
      check(oe_cnt == 0, "R8 read bus released", oe_cnt, 0);
      check(done_cnt == 1 && done_idx == s_exp + t_exp, "R9 rd_done timing", done_idx, s_exp + t_exp);
      check(done_val == bus_pattern(s_exp + t_exp - 1), "R9 read capture", done_val, bus_pattern(s_exp + t_exp - 1));
    end else begin
      check(oe_cnt == s_exp + t_exp + h_exp, "R8 R1 write drive span incl. hold", oe_cnt, s_exp + t_exp + h_exp);
      check(data_bad == 0, "R8 write data value", data_bad, 0);
      check(done_cnt == 0, "R9 no rd_done on write", done_cnt, 0);
    end
    check(!lcd_d_oe && lcd_e == 2'b00, "R8 idle bus released", {lcd_d_oe, lcd_e}, 0);
  endtask

  task automatic reset_mid_access();
    @(negedge clk);
    cfg_w_setup = 5'd2; cfg_w_strobe = 6'd40; cfg_w_hold = 4'd3; cfg_cs_gap = 5'd5;
    req_type = 2'b01; req_disp = 1'b1; req_wdata = 8'hA5; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    repeat (5) @(negedge clk);
    check(lcd_e[1] && busy, "R12 strobe active before reset", lcd_e, 2);
    rst = 1'b1;
    @(negedge clk);
    check(!busy && lcd_e == 2'b00 && !lcd_d_oe, "R12 reset to idle", {busy, lcd_e, lcd_d_oe}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && lcd_e == 2'b00, "R12 stays idle after reset", {busy, lcd_e}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    rst = 1'b1; req_valid = 1'b0; req_type = 2'b00; req_disp = 1'b0; req_wdata = 8'h00;
    cfg_w_setup = 5'd1; cfg_w_strobe = 6'd1; cfg_w_hold = 4'd1;
    cfg_r_setup = 5'd1; cfg_r_strobe = 6'd1; cfg_r_hold = 4'd1; cfg_cs_gap = 5'd0;
    lcd_d_in = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && lcd_e == 2'b00 && !lcd_d_oe && !rd_done, "R12 reset state", {busy, lcd_e, lcd_d_oe}, 0);
    rst = 1'b0;
    // directed corner cases
    run_access(2'b00, 1'b0, 8'h3C, 3, 5, 2, 9, 9, 9, 4, 1'b0);   // R1 write command
    run_access(2'b01, 1'b1, 8'hC3, 0, 4, 1, 7, 7, 7, 0, 1'b0);   // R2 no setup, R5 no gap
    run_access(2'b01, 1'b0, 8'h81, 2, 0, 0, 1, 1, 1, 1, 1'b0);   // R3 zero strobe/hold
    run_access(2'b10, 1'b1, 8'h00, 1, 1, 1, 4, 6, 3, 2, 1'b0);   // R4 read status
    run_access(2'b11, 1'b0, 8'h00, 9, 9, 9, 0, 1, 1, 0, 1'b0);   // R9 shortest read
    run_access(2'b00, 1'b1, 8'hFF, 31, 63, 15, 0, 1, 1, 31, 1'b1); // maxima, R11
    run_access(2'b11, 1'b1, 8'h00, 0, 1, 1, 31, 63, 15, 31, 1'b1); // R4 maxima, R10 held off
    reset_mid_access();
    // constrained random accesses
    for (int k = 0; k < 40; k++) begin
      run_access(2'($urandom), 1'($urandom), 8'($urandom),
                 int'($urandom_range(0, 31)), int'($urandom_range(0, 63)), int'($urandom_range(0, 15)),
                 int'($urandom_range(0, 31)), int'($urandom_range(0, 63)), int'($urandom_range(0, 15)),
                 int'($urandom_range(0, 31)), 1'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule